// File: doc/BRIEF.md
# Writeback Stage with Scoreboard Release

This block is the last stage of an in-order pipeline. It takes one finished instruction and retires it. The instruction arrives with four pieces of information: whether it is a no-op, its format class, its result value, and the destination tag that decode recorded when it reserved a register. The stage then does one of two things. It can write the result into the scalar or the vector register file and release the oldest reservation from the scoreboard queue. Or it can steer the program counter to a jump target.

The decision to write depends only on the destination tag and never on the opcode. A tag of zero or below means that nothing was reserved. The stage flags an error in two cases: a write that would pop an empty scoreboard, and a tag beyond both register files. It accepts a new instruction in the cycle after it finishes the current one. The register write and the scoreboard pop are issued on the same clock edge.

Top module: `writeback_stage`

## Requirements
- R1: While reset is held and after it is released, every strobe output (`rf_we_scalar`, `rf_we_vector`, `sb_pop`, `redirect_valid`, `wb_error`) is 0 and `in_ready` is 1.
- R2: The stage captures an instruction on an edge where `in_valid` and `in_ready` are both 1, and drives `in_ready` low for exactly one cycle. The results of that instruction appear on the following edge, and `in_ready` returns high on that same edge. If `in_valid` is held high continuously, the stage retires one instruction every two cycles.
- R3: An instruction with `in_nop` = 1, or with format code 2'b11 (invalid), produces no write, no pop, no redirect and no error.
- R4: If the tag lies in 1..GPR_NUM-1 and `sb_empty` = 0, the stage pulses `rf_we_scalar` and `sb_pop` together. In that cycle `rf_addr` equals the tag and `rf_data` equals the result. This applies to every format, including J (2'b10).
- R5: If the tag lies in GPR_NUM..GPR_NUM+VEC_NUM-1 and `sb_empty` = 0, the stage pulses `rf_we_vector` and `sb_pop` together, with `rf_addr` = tag mod GPR_NUM and `rf_data` = result.
- R6: If a write is needed (tag > 0, in range) while `sb_empty` = 1, the stage pulses `wb_error` and issues no write and no pop.
- R7: A tag greater than zero and at or above GPR_NUM+VEC_NUM pulses `wb_error` with no write and no pop, whatever the state of `sb_empty`.
- R8: If the tag is 0 or below and the format is J (2'b10), a result other than all-ones pulses `redirect_valid` for one cycle, with `redirect_pc` equal to the low PCW bits of the result.
- R9: If the tag is 0 or below and the format is J, an all-ones result (not taken) produces no output.
- R10: If the tag is 0 or below and the format is R (2'b00) or I (2'b01), the stage produces no output. Stores and compares retire this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Finished instruction offered |
| in_ready | output | 1 | Stage can capture an instruction this cycle |
| in_nop | input | 1 | Instruction is a no-op |
| in_fmt | input | 2 | Format: 00 R, 01 I, 10 J, 11 invalid |
| in_dest | input | TW | Two's-complement destination tag from decode |
| in_result | input | DW | Result value or jump target (-1 = not taken) |
| sb_empty | input | 1 | Scoreboard queue holds no reservation |
| rf_we_scalar | output | 1 | Scalar register file write strobe |
| rf_we_vector | output | 1 | Vector register file write strobe |
| rf_addr | output | AW | Register index within the selected file |
| rf_data | output | DW | Write data |
| sb_pop | output | 1 | Release the oldest scoreboard entry |
| redirect_valid | output | 1 | One-cycle PC redirect strobe |
| redirect_pc | output | PCW | Redirect target |
| wb_error | output | 1 | Empty-scoreboard pop or out-of-range tag |

## Verification
Each instruction is captured on one edge, and its write, pop, redirect or error pulse is registered on the next edge. The bench therefore drives at a falling edge and checks quiet outputs and a low `in_ready` one falling edge later. It reads the results at the falling edge after that, which is the only cycle in which a pulse can be seen. `sb_empty` is held stable across both edges, because the stage samples it on the retire edge. The back-to-back case counts pulses over four edges, and the count shows the two-cycle retire rate.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef enum logic [1:0] {
    FMT_R   = 2'b00,
    FMT_I   = 2'b01,
    FMT_J   = 2'b10,
    FMT_INV = 2'b11
  } wb_fmt_e;

  typedef struct packed {
    logic wr_s;
    logic wr_v;
    logic pop;
    logic redir;
    logic err;
  } wb_act_t;

endpackage

// File: rtl/wb_hold.sv
module wb_hold #(
  parameter int DW = 16,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_nop,
  input  logic [1:0]    in_fmt,
  input  logic [TW-1:0] in_dest,
  input  logic [DW-1:0] in_result,
  output logic          in_ready,
  output logic          held,
  output logic          h_nop,
  output logic [1:0]    h_fmt,
  output logic [TW-1:0] h_dest,
  output logic [DW-1:0] h_result
);

  logic take;
  assign in_ready = !held;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      h_nop    <= 1'b0;
      h_fmt    <= 2'b00;
      h_dest   <= '0;
      h_result <= '0;
    end else begin
      held <= take;
      if (take) begin
        h_nop    <= in_nop;
        h_fmt    <= in_fmt;
        h_dest   <= in_dest;
        h_result <= in_result;
      end
    end
  end

  // R2: a capture blocks the next cycle, and the block lasts one cycle only
  assert_capture_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_ready_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

endmodule

// File: rtl/wb_bank_map.sv
module wb_bank_map #(
  parameter int GPR_NUM = 16,
  parameter int TW      = 6,
  parameter int AW      = 4
) (
  input  logic [TW-2:0] tag_mag,
  output logic [AW-1:0] bank_idx
);

  localparam bit POW2 = (GPR_NUM & (GPR_NUM - 1)) == 0;

  function automatic logic [AW-1:0] mod_any(input logic [TW-2:0] t);
    return AW'(32'(t) % GPR_NUM);
  endfunction

  function automatic logic [AW-1:0] mod_pow2(input logic [TW-2:0] t);
    return AW'(t & (TW-1)'(GPR_NUM - 1));
  endfunction

  generate
    if (POW2) begin : g_mask
      assign bank_idx = mod_pow2(tag_mag);
    end else begin : g_div
      assign bank_idx = mod_any(tag_mag);
    end
  endgenerate

endmodule

// File: rtl/wb_decide.sv
module wb_decide
  import wb_pkg::*;
#(
  parameter int GPR_NUM = 16,
  parameter int VEC_NUM = 8,
  parameter int DW      = 16,
  parameter int TW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          held,
  input  logic          h_nop,
  input  logic [1:0]    h_fmt,
  input  logic [TW-1:0] h_dest,
  input  logic [DW-1:0] h_result,
  input  logic          sb_empty,
  output logic          need_write,
  output logic          tag_in_range,
  output wb_act_t       act
);

  localparam int TOTAL = GPR_NUM + VEC_NUM;

  function automatic logic f_positive(input logic [TW-1:0] t);
    return !t[TW-1] && (t != '0);
  endfunction

  function automatic logic f_in_range(input logic [TW-1:0] t);
    return 32'(t[TW-2:0]) < TOTAL;
  endfunction

  function automatic logic f_is_vector(input logic [TW-1:0] t);
    return 32'(t[TW-2:0]) >= GPR_NUM;
  endfunction

  function automatic logic f_not_taken(input logic [DW-1:0] r);
    return r == '1;
  endfunction

  logic active;
  logic commit;

  assign active       = held && !h_nop && (wb_fmt_e'(h_fmt) != FMT_INV);
  assign need_write   = active && f_positive(h_dest);
  assign tag_in_range = f_in_range(h_dest);
  assign commit       = need_write && tag_in_range && !sb_empty;

  always_comb begin
    act       = '0;
    act.wr_s  = commit && !f_is_vector(h_dest);
    act.wr_v  = commit && f_is_vector(h_dest);
    act.pop   = commit;
    act.err   = need_write && (!tag_in_range || sb_empty);
    act.redir = active && !need_write && (wb_fmt_e'(h_fmt) == FMT_J)
                && !f_not_taken(h_result);
  end

  // R6: an error never comes together with a pop
  assert_err_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act.err |-> !act.pop);

endmodule

// File: rtl/wb_issue.sv
module wb_issue
  import wb_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter int PCW     = 16,
  parameter int VEC_NUM = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wb_act_t       act,
  input  logic [AW-1:0] bank_idx,
  input  logic [DW-1:0] h_result,
  output logic          rf_we_scalar,
  output logic          rf_we_vector,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_data,
  output logic          sb_pop,
  output logic          redirect_valid,
  output logic [PCW-1:0] redirect_pc,
  output logic          wb_error
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we_scalar   <= 1'b0;
      rf_we_vector   <= 1'b0;
      rf_addr        <= '0;
      rf_data        <= '0;
      sb_pop         <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      wb_error       <= 1'b0;
    end else begin
      rf_we_scalar   <= act.wr_s;
      rf_we_vector   <= act.wr_v;
      sb_pop         <= act.pop;
      redirect_valid <= act.redir;
      wb_error       <= act.err;
      if (act.wr_s || act.wr_v) begin
        rf_addr <= bank_idx;
        rf_data <= h_result;
      end
      if (act.redir) redirect_pc <= h_result[PCW-1:0];
    end
  end

  // R8: at most one kind of retirement per cycle; redirect is a single pulse
  assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we_scalar, rf_we_vector, redirect_valid, wb_error}));
  assert_redirect_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);
  // R5: vector index stays inside the vector file
  assert_vec_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_vector |-> (32'(rf_addr) < VEC_NUM));
  // R4: a write always releases a reservation
  assert_write_pops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_scalar || rf_we_vector) |-> sb_pop);

endmodule

// File: rtl/writeback_stage.sv
module writeback_stage
  import wb_pkg::*;
#(
  parameter int DW      = 16,
  parameter int GPR_NUM = 16,
  parameter int VEC_NUM = 8,
  parameter int PCW     = 16,
  parameter int TW      = $clog2(GPR_NUM + VEC_NUM) + 1,
  parameter int AW      = $clog2(GPR_NUM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_nop,
  input  logic [1:0]     in_fmt,
  input  logic [TW-1:0]  in_dest,
  input  logic [DW-1:0]  in_result,
  input  logic           sb_empty,
  output logic           rf_we_scalar,
  output logic           rf_we_vector,
  output logic [AW-1:0]  rf_addr,
  output logic [DW-1:0]  rf_data,
  output logic           sb_pop,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_pc,
  output logic           wb_error
);

  localparam int TOTAL = GPR_NUM + VEC_NUM;

  logic          held;
  logic          h_nop;
  logic [1:0]    h_fmt;
  logic [TW-1:0] h_dest;
  logic [DW-1:0] h_result;
  logic [AW-1:0] bank_idx;
  logic          need_write;
  logic          tag_in_range;
  wb_act_t       act;

  wb_hold #(.DW(DW), .TW(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nop(in_nop),
    .in_fmt(in_fmt), .in_dest(in_dest), .in_result(in_result),
    .in_ready(in_ready), .held(held), .h_nop(h_nop), .h_fmt(h_fmt),
    .h_dest(h_dest), .h_result(h_result)
  );

  wb_bank_map #(.GPR_NUM(GPR_NUM), .TW(TW), .AW(AW)) u_map (
    .tag_mag(h_dest[TW-2:0]), .bank_idx(bank_idx)
  );

  wb_decide #(.GPR_NUM(GPR_NUM), .VEC_NUM(VEC_NUM), .DW(DW), .TW(TW)) u_decide (
    .clk(clk), .rst_n(rst_n), .held(held), .h_nop(h_nop), .h_fmt(h_fmt),
    .h_dest(h_dest), .h_result(h_result), .sb_empty(sb_empty),
    .need_write(need_write), .tag_in_range(tag_in_range), .act(act)
  );

  wb_issue #(.DW(DW), .AW(AW), .PCW(PCW), .VEC_NUM(VEC_NUM)) u_issue (
    .clk(clk), .rst_n(rst_n), .act(act), .bank_idx(bank_idx),
    .h_result(h_result), .rf_we_scalar(rf_we_scalar),
    .rf_we_vector(rf_we_vector), .rf_addr(rf_addr), .rf_data(rf_data),
    .sb_pop(sb_pop), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .wb_error(wb_error)
  );

  logic any_out;
  logic silent_kind;
  logic over_range;
  assign any_out     = rf_we_scalar || rf_we_vector || sb_pop || redirect_valid || wb_error;
  assign silent_kind = h_nop || (h_fmt == 2'b11);
  assign over_range  = !h_dest[TW-1] && (32'(h_dest[TW-2:0]) >= TOTAL);

  // R2: outputs only on the edge after an instruction was held
  assert_out_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(held));
  // R3: no-op and invalid instructions stay silent
  assert_silent_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (held && silent_kind) |=> !any_out);
  // R6: never pop while the scoreboard is empty
  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && sb_empty) |=> !sb_pop);
  // R7: a tag past both files flags an error
  assert_range_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !silent_kind && over_range) |=> (wb_error && !sb_pop));
  // R5/R7: a write only happens for an in-range tag
  assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act.wr_s || act.wr_v) |-> (need_write && tag_in_range));

endmodule

// File: tb/writeback_stage_tb.sv
module writeback_stage_tb_top;

  localparam int DW = 16;
  localparam int TW = 6;
  localparam int AW = 4;
  localparam int PCW = 16;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_nop = 1'b0;
  logic [1:0] in_fmt = 2'b00;
  logic [TW-1:0] in_dest = '0;
  logic [DW-1:0] in_result = '0;
  logic sb_empty = 1'b0;
  logic rf_we_scalar, rf_we_vector, sb_pop, redirect_valid, wb_error;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_data;
  logic [PCW-1:0] redirect_pc;

  always #10 clk = ~clk;

  writeback_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_nop(in_nop), .in_fmt(in_fmt), .in_dest(in_dest), .in_result(in_result),
    .sb_empty(sb_empty), .rf_we_scalar(rf_we_scalar), .rf_we_vector(rf_we_vector),
    .rf_addr(rf_addr), .rf_data(rf_data), .sb_pop(sb_pop),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .wb_error(wb_error)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        nop;
    logic [1:0]  fmt;
    logic [5:0]  dest;
    logic [15:0] res;
    logic        empty;
    logic        ws;
    logic        wv;
    logic [3:0]  addr;
    logic        pop;
    logic        redir;
    logic        err;
  } vec_t;

  // {req, nop, fmt, dest, result, sb_empty | ws, wv, addr, pop, redir, err}
  localparam logic [38:0] VECS [NV] = '{
    {4'd4,  1'b0, 2'b00, 6'd5,  16'h1234, 1'b0, 1'b1, 1'b0, 4'd5,  1'b1, 1'b0, 1'b0}, // R4
    {4'd4,  1'b0, 2'b01, 6'd15, 16'hBEEF, 1'b0, 1'b1, 1'b0, 4'd15, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4,  1'b0, 2'b10, 6'd1,  16'h0042, 1'b0, 1'b1, 1'b0, 4'd1,  1'b1, 1'b0, 1'b0}, // R4 J link
    {4'd5,  1'b0, 2'b00, 6'd16, 16'h0AAA, 1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 1'b0, 1'b0}, // R5
    {4'd5,  1'b0, 2'b01, 6'd23, 16'h5555, 1'b0, 1'b0, 1'b1, 4'd7,  1'b1, 1'b0, 1'b0}, // R5
    {4'd6,  1'b0, 2'b00, 6'd7,  16'h0777, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1}, // R6
    {4'd6,  1'b0, 2'b01, 6'd20, 16'h0888, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1}, // R6
    {4'd7,  1'b0, 2'b00, 6'd24, 16'h0999, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1}, // R7
    {4'd7,  1'b0, 2'b10, 6'd31, 16'h0111, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1}, // R7
    {4'd8,  1'b0, 2'b10, 6'd0,  16'h0100, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0}, // R8
    {4'd8,  1'b0, 2'b10, 6'h3F, 16'h7FFE, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0}, // R8
    {4'd9,  1'b0, 2'b10, 6'd0,  16'hFFFF, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0}, // R9
    {4'd10, 1'b0, 2'b01, 6'd0,  16'h1111, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0}, // R10
    {4'd10, 1'b0, 2'b00, 6'h3F, 16'h2222, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0}, // R10
    {4'd3,  1'b1, 2'b00, 6'd5,  16'h3333, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0}, // R3
    {4'd3,  1'b0, 2'b11, 6'd30, 16'h4444, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0}  // R3
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] flags();
    return {rf_we_scalar, rf_we_vector, sb_pop, redirect_valid, wb_error};
  endfunction

  initial begin
    int pops;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(flags() == 5'b0 && in_ready, "R1", "flags/ready in reset",
          {26'd0, flags(), in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags() == 5'b0 && in_ready, "R1", "flags/ready after reset",
          {26'd0, flags(), in_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v = vec_t'(VECS[i]);
      rq = $sformatf("R%0d", v.req);
      in_valid = 1'b1; in_nop = v.nop; in_fmt = v.fmt;
      in_dest = v.dest; in_result = v.res; sb_empty = v.empty;
      @(negedge clk);
      in_valid = 1'b0;
      // R2: captured, ready low, nothing issued yet
      check(!in_ready && flags() == 5'b0, "R2", "held cycle ready/flags",
            {26'd0, flags(), in_ready}, 32'h0);
      @(negedge clk);
      check(flags() == {v.ws, v.wv, v.pop, v.redir, v.err}, rq, "strobes",
            {27'd0, flags()}, {27'd0, v.ws, v.wv, v.pop, v.redir, v.err});
      if (v.ws || v.wv)
        check(rf_addr == v.addr && rf_data == v.res, rq, "addr/data",
              {12'd0, rf_addr, rf_data}, {12'd0, v.addr, v.res});
      if (v.redir)
        check(redirect_pc == v.res, rq, "redirect_pc",
              {16'd0, redirect_pc}, {16'd0, v.res});
      check(in_ready, "R2", "ready back", {31'd0, in_ready}, 32'h1);
    end

    // R2: continuous valid retires every second cycle
    sb_empty = 1'b0; in_nop = 1'b0; in_fmt = 2'b00;
    in_dest = 6'd3; in_result = 16'hCAFE; in_valid = 1'b1;
    pops = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (sb_pop) pops++;
    end
    in_valid = 1'b0;
    check(pops == 2, "R2", "pops over four edges", pops, 2);
    @(negedge clk);
    @(negedge clk);
    // R1: reset again mid-run clears strobes
    rst_n = 1'b0;
    @(negedge clk);
    check(flags() == 5'b0 && in_ready, "R1", "re-reset",
          {26'd0, flags(), in_ready}, 32'h1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule